// File: doc/BRIEF.md
# Control and Interrupt-Enable Register Pair with Completion Mirrors

This block is a small slice of a register file. It holds two writable registers: a global control word whose bits switch individual sub-units on or off, and an interrupt-enable word. Each writable register has a read-only companion one word (4 bytes) above it that reports which part of the written value the sub-units have actually taken up. A write lands in the writable register at once and drives the enable outputs. The companion only moves bit by bit, as each sub-unit signals through its ready input that it has reached the requested on or off level. Software writes a value and then polls the companion until it reads back exactly that value.

Every implemented bit has its own small tracker state machine with three states. SYNCED means the mirrored bit already equals the requested level. PEND_ON means a rise is requested and the mirror is still 0. PEND_OFF means a fall is requested and the mirror is still 1. The transitions are named as follows. `request` goes from SYNCED to PEND_ON or PEND_OFF when the requested bit differs from the mirror. `confirm` goes from a pending state to SYNCED when the unit's ready input equals the requested bit, and the mirror takes the requested level on that same edge. `cancel` goes from any state to SYNCED when a newer write makes the requested bit equal the mirror again. `hold` keeps the pending state while the unit has not yet arrived. Read data is combinational from the presented address.

Top module: `ctl_ack_regfile`

## Requirements
- R1: After reset both writable registers, both mirrors and all enable outputs are zero.
- R2: A write with `reg_sel`=1, `reg_wr`=1 and address 0x0 stores the data into the control register on that clock edge. From then on `ctl_en` carries it and a read of 0x0 returns it.
- R3: Unimplemented bits read as zero in every register and on the enable outputs. The control register implements bits 4:0 only. The interrupt-enable register implements bits 0 and 2 only, so bit 1 and bits 31:3 are zero.
- R4: A mirror bit changes only to the level that the matching ready input showed at that clock edge. While the ready input differs from the requested level, the mirror bit holds its old value.
- R5: When ready already matches, the mirror picks up a newly written bit on the second clock edge after the write edge, and not before.
- R6: A write made while a bit is still pending restarts tracking against the newest value. A cancelled request is never confirmed, even if the unit later reports the cancelled level.
- R7: The mirrors sit at 0x4 (control) and 0xC (interrupt enable). Writes to these addresses are ignored.
- R8: Reads of any other address return zero, and writes to them change nothing.
- R9: A write to address 0x8 sets the interrupt-enable register: bit 0 enables global-error interrupts and bit 2 enables event-queue interrupts. Its mirror follows `irq_rdy` in the same way as the control mirror.
- R10: The control bits are fixed: bit 0 translation, bit 1 page-request queue, bit 2 event queue, bit 3 command queue, bit 4 request checking. Each bit is tracked on its own, so a slow unit delays only its own mirror bit.
- R11: The bring-up order works when each step waits for the mirror to equal the written value. The order is all-zero, then command queue, then event queue, then checking, then translation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_sel | input | 1 | Register access strobe |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | ADDR_W (4) | Byte address of the register |
| reg_wdata | input | DATA_W (32) | Write data |
| reg_rdata | output | DATA_W (32) | Read data for `reg_addr`, combinational |
| ctl_en | output | CTL_W (5) | Per-unit enables from the control register |
| ctl_rdy | input | CTL_W (5) | Per-unit reported state, 1 = enabled |
| irq_en | output | IRQ_W (3) | Interrupt enables (bit 1 always 0) |
| irq_rdy | input | IRQ_W (3) | Interrupt logic reported state per bit |

## Verification
The bench attacks the window where a request is pending and a newer write reverses it. A tracker that fails to cancel would later raise the mirror to a level nobody asked for, which leaves software believing a unit is on when it is off. The bench also measures the two-edge latency of the mirror, which catches a mirror that copies the written value directly. It holds single ready inputs low while the others are high, which shows whether one slow unit blocks the whole mirror. Finally it writes to the read-only and unmapped addresses and to unimplemented bit positions, and reads back both registers to show that no stray state appeared.

// File: rtl/ctl_ack_pkg.sv
package cak_pkg;

    // control bit positions (decoded by sub-units)
    localparam int unsigned CAK_BIT_XLATE  = 0;
    localparam int unsigned CAK_BIT_PRQ    = 1;
    localparam int unsigned CAK_BIT_EVQ    = 2;
    localparam int unsigned CAK_BIT_CMDQ   = 3;
    localparam int unsigned CAK_BIT_REQCHK = 4;

    // interrupt-enable bit positions
    localparam int unsigned CAK_IRQ_GERR   = 0;
    localparam int unsigned CAK_IRQ_EVQ    = 2;

    localparam int unsigned CAK_CTL_W = 5;
    localparam int unsigned CAK_IRQ_W = 3;

    localparam int unsigned CAK_CTL_MASK = (1 << CAK_BIT_XLATE) | (1 << CAK_BIT_PRQ) |
                                           (1 << CAK_BIT_EVQ) | (1 << CAK_BIT_CMDQ) |
                                           (1 << CAK_BIT_REQCHK);
    localparam int unsigned CAK_IRQ_MASK = (1 << CAK_IRQ_GERR) | (1 << CAK_IRQ_EVQ);

    // byte offsets; each mirror sits one word above its register
    localparam int unsigned CAK_CTL_OFS  = 0;
    localparam int unsigned CAK_IRQ_OFS  = 8;
    localparam int unsigned CAK_ACK_STEP = 4;

    typedef enum logic [1:0] {
        TRK_SYNCED   = 2'd0,
        TRK_PEND_ON  = 2'd1,
        TRK_PEND_OFF = 2'd2
    } trk_state_t;

endpackage

// File: rtl/ack_bit_tracker.sv
module ack_bit_tracker
    import cak_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic target,
    input  logic rdy,
    output logic ack
);

    trk_state_t state_q, state_d;
    logic       ack_q, ack_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TRK_SYNCED;
        else        state_q <= state_d;
    end

    // next state and next mirror value
    always_comb begin
        state_d = state_q;
        ack_d   = ack_q;
        if (target == ack_q) begin
            state_d = TRK_SYNCED;                    // cancel / already there
        end else begin
            unique case (state_q)
                TRK_SYNCED: begin                    // request
                    state_d = target ? TRK_PEND_ON : TRK_PEND_OFF;
                end
                TRK_PEND_ON, TRK_PEND_OFF: begin
                    if (rdy == target) begin         // confirm
                        ack_d   = target;
                        state_d = TRK_SYNCED;
                    end else begin                   // hold
                        state_d = target ? TRK_PEND_ON : TRK_PEND_OFF;
                    end
                end
                default: state_d = TRK_SYNCED;
            endcase
        end
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ack_q <= 1'b0;
        else        ack_q <= ack_d;
    end

    assign ack = ack_q;

endmodule

// File: rtl/ctl_mirror_reg.sv
module ctl_mirror_reg
    import cak_pkg::*;
#(
    parameter int unsigned   DATA_W = 32,
    parameter int unsigned   W      = CAK_CTL_W,
    parameter logic [W-1:0]  MASK   = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic [W-1:0]      rdy,
    output logic [W-1:0]      value,
    output logic [W-1:0]      ack
);

    localparam logic [DATA_W-1:0] WIDE_MASK = DATA_W'(MASK);

    logic [W-1:0] value_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     value_q <= '0;
        else if (wr_en) value_q <= W'(wdata & WIDE_MASK);
    end

    // one tracker per bit; masked bits have a constant-zero target
    for (genvar b = 0; b < W; b++) begin : g_trk
        ack_bit_tracker u_trk (
            .clk    (clk),
            .rst_n  (rst_n),
            .target (value_q[b]),
            .rdy    (rdy[b]),
            .ack    (ack[b])
        );
    end

    assign value = value_q;

endmodule

// File: rtl/ctl_ack_regfile.sv
module ctl_ack_regfile
    import cak_pkg::*;
#(
    parameter int unsigned      DATA_W   = 32,
    parameter int unsigned      ADDR_W   = 4,
    parameter int unsigned      CTL_W    = CAK_CTL_W,
    parameter int unsigned      IRQ_W    = CAK_IRQ_W,
    parameter logic [CTL_W-1:0] CTL_MASK = CTL_W'(CAK_CTL_MASK),
    parameter logic [IRQ_W-1:0] IRQ_MASK = IRQ_W'(CAK_IRQ_MASK)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_sel,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [CTL_W-1:0]  ctl_en,
    input  logic [CTL_W-1:0]  ctl_rdy,
    output logic [IRQ_W-1:0]  irq_en,
    input  logic [IRQ_W-1:0]  irq_rdy
);

    localparam logic [ADDR_W-1:0] A_CTL     = ADDR_W'(CAK_CTL_OFS);
    localparam logic [ADDR_W-1:0] A_CTL_ACK = ADDR_W'(CAK_CTL_OFS + CAK_ACK_STEP);
    localparam logic [ADDR_W-1:0] A_IRQ     = ADDR_W'(CAK_IRQ_OFS);
    localparam logic [ADDR_W-1:0] A_IRQ_ACK = ADDR_W'(CAK_IRQ_OFS + CAK_ACK_STEP);

    logic             wr_ctl, wr_irq;
    logic [CTL_W-1:0] ctl_ack;
    logic [IRQ_W-1:0] irq_ack;

    assign wr_ctl = reg_sel && reg_wr && (reg_addr == A_CTL);
    assign wr_irq = reg_sel && reg_wr && (reg_addr == A_IRQ);

    ctl_mirror_reg #(
        .DATA_W (DATA_W),
        .W      (CTL_W),
        .MASK   (CTL_MASK)
    ) u_ctl (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_ctl),
        .wdata  (reg_wdata),
        .rdy    (ctl_rdy),
        .value  (ctl_en),
        .ack    (ctl_ack)
    );

    ctl_mirror_reg #(
        .DATA_W (DATA_W),
        .W      (IRQ_W),
        .MASK   (IRQ_MASK)
    ) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_irq),
        .wdata  (reg_wdata),
        .rdy    (irq_rdy),
        .value  (irq_en),
        .ack    (irq_ack)
    );

    always_comb begin
        unique case (reg_addr)
            A_CTL:     reg_rdata = DATA_W'(ctl_en);
            A_CTL_ACK: reg_rdata = DATA_W'(ctl_ack);
            A_IRQ:     reg_rdata = DATA_W'(irq_en);
            A_IRQ_ACK: reg_rdata = DATA_W'(irq_ack);
            default:   reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/ctl_ack_regfile_chk.sv
module ctl_ack_regfile_chk
    import cak_pkg::*;
#(
    parameter int unsigned      DATA_W   = 32,
    parameter int unsigned      ADDR_W   = 4,
    parameter int unsigned      CTL_W    = CAK_CTL_W,
    parameter int unsigned      IRQ_W    = CAK_IRQ_W,
    parameter logic [CTL_W-1:0] CTL_MASK = CTL_W'(CAK_CTL_MASK),
    parameter logic [IRQ_W-1:0] IRQ_MASK = IRQ_W'(CAK_IRQ_MASK)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_sel,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [CTL_W-1:0]  ctl_en,
    input logic [CTL_W-1:0]  ctl_rdy,
    input logic [IRQ_W-1:0]  irq_en,
    input logic [IRQ_W-1:0]  irq_rdy,
    input logic [CTL_W-1:0]  ctl_ack,
    input logic [IRQ_W-1:0]  irq_ack
);

    localparam logic [ADDR_W-1:0] A_CTL     = ADDR_W'(CAK_CTL_OFS);
    localparam logic [ADDR_W-1:0] A_CTL_ACK = ADDR_W'(CAK_CTL_OFS + CAK_ACK_STEP);
    localparam logic [ADDR_W-1:0] A_IRQ     = ADDR_W'(CAK_IRQ_OFS);

    logic past_ok;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // a mirror bit may only move to the level its ready input showed
    assert_ack_needs_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> ((({irq_ack, ctl_ack} ^ $past({irq_ack, ctl_ack})) &
                      ($past({irq_rdy, ctl_rdy}) ^ {irq_ack, ctl_ack})) == '0));

    // a mirror bit may only move to the level already held in the register
    assert_ack_after_target_R5: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> ((({irq_ack, ctl_ack} ^ $past({irq_ack, ctl_ack})) &
                      ($past({irq_en, ctl_en}) ^ {irq_ack, ctl_ack})) == '0));

    assert_ctl_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(reg_sel && reg_wr && (reg_addr == A_CTL))
        |-> (ctl_en == ($past(reg_wdata[CTL_W-1:0]) & CTL_MASK)));

    assert_irq_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(reg_sel && reg_wr && (reg_addr == A_IRQ))
        |-> (irq_en == ($past(reg_wdata[IRQ_W-1:0]) & IRQ_MASK)));

    assert_unimpl_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((ctl_en & ~CTL_MASK) == '0) && ((ctl_ack & ~CTL_MASK) == '0) &&
        ((irq_en & ~IRQ_MASK) == '0) && ((irq_ack & ~IRQ_MASK) == '0));

    assert_ack_write_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(reg_sel && reg_wr && (reg_addr == A_CTL_ACK))
        |-> (ctl_en == $past(ctl_en)));

endmodule

bind ctl_ack_regfile ctl_ack_regfile_chk #(
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W),
    .CTL_W    (CTL_W),
    .IRQ_W    (IRQ_W),
    .CTL_MASK (CTL_MASK),
    .IRQ_MASK (IRQ_MASK)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_sel   (reg_sel),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .ctl_en    (ctl_en),
    .ctl_rdy   (ctl_rdy),
    .irq_en    (irq_en),
    .irq_rdy   (irq_rdy),
    .ctl_ack   (ctl_ack),
    .irq_ack   (irq_ack)
);

// File: tb/ctl_ack_regfile_tb.sv
`timescale 1ns/1ps
module ctl_ack_regfile_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_sel = 1'b0, reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [4:0]  ctl_en, ctl_rdy, ctl_rdy_man = '0;
    logic [2:0]  irq_en, irq_rdy, irq_rdy_man = '0;
    logic        follow = 1'b0;
    logic [4:0]  ctl_d1 = '0, ctl_d2 = '0;
    logic [2:0]  irq_d1 = '0, irq_d2 = '0;

    int checks = 0, errors = 0, cycles = 0;
    bit done = 0;

    always #5 clk = ~clk;

    // unit model: in follow mode, ready trails the enables by two cycles
    always @(posedge clk) begin
        ctl_d1 <= ctl_en; ctl_d2 <= ctl_d1;
        irq_d1 <= irq_en; irq_d2 <= irq_d1;
    end
    assign ctl_rdy = follow ? ctl_d2 : ctl_rdy_man;
    assign irq_rdy = follow ? irq_d2 : irq_rdy_man;

    ctl_ack_regfile u_dut (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ctl_en(ctl_en), .ctl_rdy(ctl_rdy), .irq_en(irq_en), .irq_rdy(irq_rdy)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_sel = 1'b1; reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_sel = 1'b0; reg_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; follow = 1'b0; ctl_rdy_man = '0; irq_rdy_man = '0;
        wait_cyc(2);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic poll_ack(input logic [3:0] a, input logic [31:0] want, input string req);
        logic [31:0] v;
        v = '0;
        for (int i = 0; i < 50; i++) begin
            bus_read(a, v);
            if (v == want) break;
            @(negedge clk);
        end
        chk(req, v, want);
    endtask

    // {irq_sel, wdata[7:0], rdy[4:0], exp_value[4:0], exp_ack[4:0]}
    localparam logic [23:0] VEC [8] = '{
        {1'b0, 8'h1F, 5'h1F, 5'h1F, 5'h1F},
        {1'b0, 8'h05, 5'h05, 5'h05, 5'h05},
        {1'b0, 8'hFF, 5'h05, 5'h1F, 5'h05},
        {1'b0, 8'h1A, 5'h1A, 5'h1A, 5'h1A},
        {1'b0, 8'h00, 5'h10, 5'h00, 5'h10},
        {1'b1, 8'h07, 5'h07, 5'h05, 5'h05},
        {1'b1, 8'h00, 5'h01, 5'h00, 5'h01},
        {1'b1, 8'h04, 5'h04, 5'h04, 5'h04}
    };

    initial begin
        logic [31:0] v;
        v = '0;
        do_reset();

        // R1 reset state
        chk("R1 ctl_en", {27'd0, ctl_en}, 32'h0);
        chk("R1 irq_en", {29'd0, irq_en}, 32'h0);
        bus_read(4'h4, v); chk("R1 ctl mirror", v, 32'h0);
        bus_read(4'hC, v); chk("R1 irq mirror", v, 32'h0);

        // vector table: R2 R3 R4 R9
        for (int k = 0; k < 8; k++) begin
            logic        is_irq;
            logic [3:0]  base;
            is_irq = VEC[k][23];
            base   = is_irq ? 4'h8 : 4'h0;
            bus_write(base, {24'd0, VEC[k][22:15]});
            if (is_irq) irq_rdy_man = VEC[k][12:10];
            else        ctl_rdy_man = VEC[k][14:10];
            wait_cyc(3);
            bus_read(base, v);
            chk(is_irq ? "R9/R3 irq value" : "R2/R3 ctl value", v, {27'd0, VEC[k][9:5]});
            bus_read(base + 4'h4, v);
            chk(is_irq ? "R9/R4 irq mirror" : "R4 ctl mirror", v, {27'd0, VEC[k][4:0]});
        end

        // R5 latency: ready already matching
        do_reset();
        ctl_rdy_man = 5'h08;
        bus_write(4'h0, 32'h08);
        chk("R2 ctl_en after write", {27'd0, ctl_en}, 32'h08);
        bus_read(4'h4, v); chk("R5 mirror at write edge", v, 32'h0);
        @(negedge clk);
        bus_read(4'h4, v); chk("R5 mirror one edge later", v, 32'h0);
        @(negedge clk);
        bus_read(4'h4, v); chk("R5 mirror two edges later", v, 32'h08);

        // R6 restart on newest value
        bus_write(4'h0, 32'h0C);
        wait_cyc(3);
        bus_read(4'h4, v); chk("R6 pending bit held", v, 32'h08);
        bus_write(4'h0, 32'h08);
        @(negedge clk);
        ctl_rdy_man = 5'h0C;
        wait_cyc(3);
        bus_read(4'h4, v); chk("R6 cancelled request not confirmed", v, 32'h08);
        bus_write(4'h0, 32'h0C);
        wait_cyc(3);
        bus_read(4'h4, v); chk("R6 re-request confirmed", v, 32'h0C);

        // R7 mirrors are read-only
        bus_write(4'h4, 32'h1F);
        chk("R7 ctl_en unchanged", {27'd0, ctl_en}, 32'h0C);
        wait_cyc(2);
        bus_read(4'h4, v); chk("R7 ctl mirror unchanged", v, 32'h0C);
        bus_write(4'hC, 32'h05);
        wait_cyc(2);
        chk("R7 irq_en unchanged", {29'd0, irq_en}, 32'h0);
        bus_read(4'hC, v); chk("R7 irq mirror unchanged", v, 32'h0);

        // R8 unmapped addresses
        bus_write(4'h6, 32'hFFFF_FFFF);
        wait_cyc(2);
        bus_read(4'h6, v); chk("R8 unmapped read", v, 32'h0);
        bus_read(4'h0, v); chk("R8 ctl untouched", v, 32'h0C);
        bus_read(4'h8, v); chk("R8 irq untouched", v, 32'h0);

        // R10 per-bit independence: page-request queue (bit1) and command queue (bit3) slow
        ctl_rdy_man = 5'h15;
        bus_write(4'h0, 32'h1F);
        chk("R10 all enables driven", {27'd0, ctl_en}, 32'h1F);
        wait_cyc(4);
        bus_read(4'h4, v); chk("R10 slow bit lags alone", v, 32'h1D);
        ctl_rdy_man = 5'h1F;
        wait_cyc(3);
        bus_read(4'h4, v); chk("R10 slow bit catches up", v, 32'h1F);

        // R11 bring-up order with polling, units follow their enables
        do_reset();
        follow = 1'b1;
        bus_write(4'h0, 32'h00); poll_ack(4'h4, 32'h00, "R11 step zero");
        bus_write(4'h0, 32'h08); poll_ack(4'h4, 32'h08, "R11 command queue");
        bus_write(4'h0, 32'h0C); poll_ack(4'h4, 32'h0C, "R11 event queue");
        bus_write(4'h0, 32'h1C); poll_ack(4'h4, 32'h1C, "R11 checking");
        bus_write(4'h0, 32'h1D); poll_ack(4'h4, 32'h1D, "R11 translation");
        chk("R10 translation enable on bit0", {31'd0, ctl_en[0]}, 32'h1);
        bus_write(4'h8, 32'h00); poll_ack(4'hC, 32'h00, "R9 irq zero");
        bus_write(4'h8, 32'h05); poll_ack(4'hC, 32'h05, "R9 irq enables");

        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule